// File: doc/BRIEF.md
# Pulse-Width Bit Decoder

This block recovers words from a single-wire serial line that rests high when idle. Every bit opens with a falling edge, and the length of the low pulse that follows carries the value. A short low of about one slot (a quarter of the bit period) is a one. A long low of about three slots is a zero. The line input is asynchronous. It is brought into the system clock domain, and its falling edges are found there. The line is never used as a clock.

A clock-enable divider on the system clock produces a slot tick. Every detected falling edge restarts both the divider and a slot counter, so the sampling phase follows the sender's edges. The bit value is read two slots after each edge, where the two pulse widths differ. It is stored at the next free index of a word buffer.

When six slot ticks pass without a new falling edge, the word is closed. For one clock the block raises a done strobe and presents the word, its bit count and an overrun flag. These outputs then hold until the next word closes. A downstream replay stage can use the count to send the word back with the same length.

Top module: `pulse_bit_rx`

## Requirements
- R1: After reset, `done_o`, `err_o`, `word_o` and `len_o` are all zero.
- R2: A bit whose low pulse lasts one slot decodes as 1. A bit whose low pulse lasts three slots decodes as 0. The value is taken two slot periods after the falling edge that starts the bit.
- R3: Every falling edge restarts the slot timing. Words are decoded correctly when the bit period is anywhere from 3.5 to 5 slots, including 4 slots.
- R4: The first bit received goes to `word_o[0]`, and each later bit goes to the next higher index. Positions at or above `len_o` read zero.
- R5: A word closes when no falling edge has arrived for six slot ticks after the last edge. The done strobe comes between 5 and 7 slot periods after the last bit's falling edge.
- R6: `len_o` equals the number of bits received in the word, for every length from 1 up to `MAX_BITS`.
- R7: `done_o` is high for exactly one clock per word. `word_o`, `len_o` and `err_o` keep their values until the next word closes.
- R8: If a word has more than `MAX_BITS` bits, the extra bits are dropped. The word is reported with `err_o` = 1 and `len_o` = `MAX_BITS`. A word of exactly `MAX_BITS` bits reports `err_o` = 0.
- R9: A line held high never produces a done strobe.
- R10: Each word starts from an empty buffer. Bits, count and overrun flag from the previous word do not carry over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_i | input | 1 | Asynchronous serial line, idle high |
| word_o | output | MAX_BITS | Last completed word, first bit at index 0 |
| len_o | output | $clog2(MAX_BITS+1) | Number of bits stored in `word_o` |
| done_o | output | 1 | One-clock strobe when a word closes |
| err_o | output | 1 | Last word had more than `MAX_BITS` bits |

## Verification
The bench runs a small configuration: four clocks per slot and a twelve-bit word. It sends every bit pattern of every length from one to six. Each value appears at each position, so a swapped decoding or a reversed bit order shows up on some word. Full-length words of all ones, all zeros and a mixed pattern separate the exact boundary from an overrun. A fifteen-bit word checks that extra bits are dropped and that the flag is cleared on the following word. Words sent with bit periods of 3.5 and 5 slots show whether the timer really re-aligns on each edge. Long idle stretches show that no false word is reported.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

  // Slot timer state: waiting for the first edge of a word, or inside one.
  typedef enum logic {
    TMR_IDLE = 1'b0,
    TMR_BUSY = 1'b1
  } tmr_state_e;

  // Strobes passed from the slot timer to the word capture stage.
  typedef struct packed {
    logic sample;   // read the bit value now
    logic close;    // edge timeout, word finished
  } tmr_evt_t;

endpackage

// File: rtl/pbr_rst_sync.sv
module pbr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/pbr_line_sync.sv
module pbr_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic fall_o
);

  logic meta_q, stable_q, prev_q;
  logic meta_d, stable_d, prev_d;

  always_comb begin
    meta_d   = line_i;
    stable_d = meta_q;
    prev_d   = stable_q;
  end

  // Idle-high line: all stages reset to one so reset release is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= 1'b1;
      stable_q <= 1'b1;
      prev_q   <= 1'b1;
    end else begin
      meta_q   <= meta_d;
      stable_q <= stable_d;
      prev_q   <= prev_d;
    end
  end

  assign level_o = stable_q;
  assign fall_o  = prev_q & ~stable_q;

endmodule

// File: rtl/pbr_slot_timer.sv
module pbr_slot_timer
  import pbr_pkg::*;
#(
  parameter int CLKS_PER_SLOT = 250,
  parameter int SAMPLE_SLOTS  = 2,
  parameter int CLOSE_SLOTS   = 6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fall_i,
  output tmr_evt_t evt_o
);

  localparam int DIV_W  = (CLKS_PER_SLOT > 1) ? $clog2(CLKS_PER_SLOT) : 1;
  localparam int SLOT_W = $clog2(CLOSE_SLOTS + 1);
  localparam logic [DIV_W-1:0]  DIV_LAST    = DIV_W'(CLKS_PER_SLOT - 1);
  localparam logic [SLOT_W-1:0] SLOT_SAMPLE = SLOT_W'(SAMPLE_SLOTS - 1);
  localparam logic [SLOT_W-1:0] SLOT_CLOSE  = SLOT_W'(CLOSE_SLOTS - 1);

  logic [DIV_W-1:0]  div_q, div_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  tmr_state_e        state_q, state_d;
  logic              tick;
  tmr_evt_t          evt;

  // Slot divider: a clock enable, restarted on every falling edge.
  assign tick = (div_q == DIV_LAST) && !fall_i;

  always_comb begin
    if (fall_i || (div_q == DIV_LAST)) begin
      div_d = '0;
    end else begin
      div_d = div_q + DIV_W'(1);
    end
  end

  // Slot counter and word-open state.
  always_comb begin
    state_d    = state_q;
    slot_d     = slot_q;
    evt.sample = 1'b0;
    evt.close  = 1'b0;
    if (fall_i) begin
      state_d = TMR_BUSY;
      slot_d  = '0;
    end else if ((state_q == TMR_BUSY) && tick) begin
      if (slot_q == SLOT_SAMPLE) begin
        evt.sample = 1'b1;
      end
      if (slot_q == SLOT_CLOSE) begin
        evt.close = 1'b1;
        state_d   = TMR_IDLE;
        slot_d    = '0;
      end else begin
        slot_d = slot_q + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      slot_q  <= '0;
      state_q <= TMR_IDLE;
    end else begin
      div_q   <= div_d;
      slot_q  <= slot_d;
      state_q <= state_d;
    end
  end

  assign evt_o = evt;

  // R3: an edge restarts the divider, so no tick can follow it directly.
  generate
    if (CLKS_PER_SLOT > 1) begin : g_realign_chk
      a_r3_edge_realigns: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i |=> !tick);
    end
  endgenerate

  // R9: no strobe is produced while no word is open.
  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TMR_IDLE && !fall_i) |=> !(evt_o.close && $past(state_q == TMR_IDLE)));

endmodule

// File: rtl/pbr_word_capture.sv
module pbr_word_capture
  import pbr_pkg::*;
#(
  parameter int MAX_BITS = 86,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                level_i,
  input  tmr_evt_t            evt_i,
  output logic [MAX_BITS-1:0] word_o,
  output logic [LEN_W-1:0]    len_o,
  output logic                done_o,
  output logic                err_o
);

  localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(MAX_BITS);

  logic [MAX_BITS-1:0] buf_q, buf_d;
  logic [LEN_W-1:0]    cnt_q, cnt_d;
  logic                ovf_q, ovf_d;
  logic [MAX_BITS-1:0] word_q, word_d;
  logic [LEN_W-1:0]    len_q, len_d;
  logic                err_q, err_d;
  logic                done_q, done_d;

  always_comb begin
    buf_d  = buf_q;
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    word_d = word_q;
    len_d  = len_q;
    err_d  = err_q;
    done_d = 1'b0;
    if (evt_i.sample) begin
      if (cnt_q < LEN_FULL) begin
        buf_d[cnt_q] = level_i;
        cnt_d        = cnt_q + LEN_W'(1);
      end else begin
        ovf_d = 1'b1;
      end
    end
    if (evt_i.close) begin
      done_d = 1'b1;
      word_d = buf_q;
      len_d  = cnt_q;
      err_d  = ovf_q;
      buf_d  = '0;
      cnt_d  = '0;
      ovf_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      word_q <= '0;
      len_q  <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
      word_q <= word_d;
      len_q  <= len_d;
      err_q  <= err_d;
      done_q <= done_d;
    end
  end

  assign word_o = word_q;
  assign len_o  = len_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  // R7: the done strobe lasts one clock.
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: results hold between strobes.
  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(word_o) && $stable(len_o) && $stable(err_o));

  // R6: reported length never exceeds the buffer.
  a_r6_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> len_o <= LEN_FULL);

  // R8: an overrun is only reported on a full buffer.
  a_r8_err_full: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> len_o == LEN_FULL);

endmodule

// File: rtl/pulse_bit_rx.sv
module pulse_bit_rx
  import pbr_pkg::*;
#(
  parameter int CLKS_PER_SLOT = 250,
  parameter int MAX_BITS      = 86,
  parameter int SAMPLE_SLOTS  = 2,
  parameter int CLOSE_SLOTS   = 6,
  parameter int LEN_W         = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_i,
  output logic [MAX_BITS-1:0] word_o,
  output logic [LEN_W-1:0]    len_o,
  output logic                done_o,
  output logic                err_o
);

  logic     rst_n_int;
  logic     level;
  logic     fall;
  tmr_evt_t evt;

  pbr_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pbr_line_sync i_line_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .line_i  (line_i),
    .level_o (level),
    .fall_o  (fall)
  );

  pbr_slot_timer #(
    .CLKS_PER_SLOT (CLKS_PER_SLOT),
    .SAMPLE_SLOTS  (SAMPLE_SLOTS),
    .CLOSE_SLOTS   (CLOSE_SLOTS)
  ) i_slot_timer (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .fall_i (fall),
    .evt_o  (evt)
  );

  pbr_word_capture #(
    .MAX_BITS (MAX_BITS),
    .LEN_W    (LEN_W)
  ) i_word_capture (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .level_i (level),
    .evt_i   (evt),
    .word_o  (word_o),
    .len_o   (len_o),
    .done_o  (done_o),
    .err_o   (err_o)
  );

  // R5: a word can only close after the line has been quiet, never on an edge.
  a_r5_close_not_on_edge: assert property (@(posedge clk) disable iff (!rst_n_int)
    fall |=> !done_o);

endmodule

// File: tb/test_pulse_bit_rx.sv
module test_pulse_bit_rx;

  localparam int CPS   = 4;
  localparam int MAXB  = 12;
  localparam int LEN_W = $clog2(MAXB + 1);

  logic            clk;
  logic            rst_n;
  logic            line;
  logic [MAXB-1:0] word_o;
  logic [LEN_W-1:0] len_o;
  logic            done_o;
  logic            err_o;

  int tests;
  int fails;
  int cycles;
  bit finished;

  pulse_bit_rx #(
    .CLKS_PER_SLOT (CPS),
    .MAX_BITS      (MAXB)
  ) i_pulse_bit_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (line),
    .word_o (word_o),
    .len_o  (len_o),
    .done_o (done_o),
    .err_o  (err_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000 && !finished) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Send n bits (LSB first) with the given period in clocks, then await done.
  task automatic send_word(input logic [15:0] bits, input int n, input int period,
                           input string req);
    int since;
    bit got;
    int exp_len;
    logic [MAXB-1:0] exp_word;
    since = 0;
    for (int i = 0; i < n; i++) begin
      int lo;
      lo = bits[i] ? CPS : 3 * CPS;
      since = 0;
      for (int c = 0; c < period; c++) begin
        @(negedge clk);
        line = (c < lo) ? 1'b0 : 1'b1;
        since++;
      end
    end
    exp_len  = (n > MAXB) ? MAXB : n;
    exp_word = '0;
    for (int i = 0; i < exp_len; i++) exp_word[i] = bits[i];
    got = 0;
    for (int c = 0; c < 300 && !got; c++) begin
      @(negedge clk);
      line = 1'b1;
      since++;
      if (done_o) got = 1;
    end
    chk(got, "R5", "done seen", got, 1);
    if (got) begin
      chk(since >= 5 * CPS && since <= 7 * CPS + 6, "R5", "close latency", since, 6 * CPS);
      chk(word_o == exp_word, req, "word (R2 R4)", word_o, exp_word);
      chk(len_o == LEN_W'(exp_len), "R6", "length", len_o, exp_len);
      chk(err_o == (n > MAXB), "R8", "overrun flag", err_o, n > MAXB);
      @(negedge clk);
      chk(done_o == 1'b0, "R7", "done one clock", done_o, 0);
    end
    repeat (3 * CPS) @(negedge clk);
  endtask

  initial begin
    bit seen;
    tests = 0; fails = 0; cycles = 0; finished = 0;
    line = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(done_o == 0 && err_o == 0 && word_o == 0 && len_o == 0,
        "R1", "reset outputs", {done_o, err_o, len_o}, 0);
    rst_n = 1'b1;

    // R9: idle line, no word.
    seen = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (done_o) seen = 1;
    end
    chk(!seen, "R9", "idle done", seen, 0);

    // R2 R4 R6 R10: every pattern of every length 1..6, nominal period.
    for (int n = 1; n <= 6; n++) begin
      for (int p = 0; p < (1 << n); p++) begin
        send_word(16'(p), n, 4 * CPS, "R4");
      end
    end

    // R8: boundary and overrun, then a fresh short word (R10).
    send_word(16'h0FFF, MAXB, 4 * CPS, "R8");
    send_word(16'h0000, MAXB, 4 * CPS, "R8");
    send_word(16'h0A5C, MAXB, 4 * CPS, "R6");
    send_word(16'h7A53, 15, 4 * CPS, "R8");
    send_word(16'h0002, 3, 4 * CPS, "R10");

    // R3: short and long bit periods.
    send_word(16'h0B6D, MAXB, 3 * CPS + 2, "R3");
    send_word(16'h0493, MAXB, 5 * CPS, "R3");
    send_word(16'h0035, 7, 3 * CPS + 2, "R3");

    // R7: outputs held after the strobe, line idle.
    repeat (100) @(negedge clk);
    chk(word_o == 12'h035 && len_o == LEN_W'(7), "R7", "held word", word_o, 12'h035);
    seen = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (done_o) seen = 1;
    end
    chk(!seen, "R9", "idle after word", seen, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule